// File: doc/BRIEF.md
# Keyed Watchdog Timer Controller

A watchdog timer that has to be kicked with a key sequence and set up through a guarded control register. The timebase is the input clock divided by a fixed power-of-two stage (`FIX_DIV`, 512 by default) and then by a selectable prescaler. An up-counter advances once per timebase tick. If the counter would wrap past its all-ones value, the block drives a reset pulse of fixed length (`PULSE_LEN` clocks). It also raises a sticky cause flag and puts the control fields back to their defaults.

Software reaches the block through an 8-bit control word. A write lands only while a write-protect window is open. The window opens with a one-cycle `prot_open` strobe and closes with `prot_close`. Each write must carry the check pattern 101 in its check field. An accepted write with any other pattern is a fault, and it fires the reset pulse at once. The counter and the prescaler phase are cleared when the service port receives `KEY_FIRST` followed by `KEY_SECOND`.

A main state machine runs the control flow. Its states are **COUNT** (counting), **HOLD** (disabled, counter frozen) and **PULSE** (reset asserted). Its transitions are:
- COUNT→HOLD when the disable bit is set.
- HOLD→COUNT when the disable bit is clear.
- COUNT→PULSE or HOLD→PULSE on a fire event, which is an overflow or a bad-pattern write.
- PULSE→COUNT after `PULSE_LEN` cycles.

A second machine tracks the service key. Its states are **KEY_IDLE** and **KEY_ARMED**:
- KEY_IDLE→KEY_ARMED on `KEY_FIRST`.
- KEY_ARMED→KEY_IDLE on `KEY_SECOND`, which services the watchdog, or on any other key.
- KEY_ARMED stays armed on a repeated `KEY_FIRST`.
- Either state goes to KEY_IDLE on a fire event or while the pulse is active.

Top module: `wdog_ctrl`

## Requirements
- R1: After `rst_n` is released, `ctl_rdata` is 0x00, `wd_cnt` is 0, `wd_rst` is 0 and the write window is closed. The block starts counting, because the disable bit resets to 0.
- R2: The prescale field sits in control bits [2:0]. While counting, `wd_cnt` increments once every `FIX_DIV` clocks when the field is 0, and every `FIX_DIV*2^(p-1)` clocks when it holds p>0.
- R3: A tick arriving while `wd_cnt` is all ones fires the block. `wd_rst` goes high from the next cycle for exactly `PULSE_LEN` cycles, and `wd_cnt` returns to 0. The flag (bit 7) reads 1. The prescale and disable fields read 0, and the window closes.
- R4: The check field occupies bits [5:3] and must be 101. An accepted write with any other value changes no field through the write itself. It fires the reset exactly as R3 describes, whatever the disable bit holds.
- R5: A write is accepted only while the window is open. A `prot_open` strobe opens the window from the next cycle, and a `prot_close` strobe closes it. Strobing both in one cycle leaves it closed. Writes made while the window is closed are ignored, including writes with a bad check pattern.
- R6: The disable bit is bit 6. Setting it stops counting with `wd_cnt` held, starting one cycle after the field updates. Clearing it resumes counting from the held value. Writing 0x68 reads back as 0x40 and disables the watchdog.
- R7: An accepted write with bit 7 set clears the flag. With bit 7 clear, the write leaves the flag as it was.
- R8: A `svc_wr` strobe carrying `KEY_FIRST` followed by a strobe carrying `KEY_SECOND` clears `wd_cnt` and the prescaler phase. A different key in between aborts the sequence. A repeated `KEY_FIRST` keeps the sequence armed. `KEY_SECOND` on its own has no effect.
- R9: If a service sequence completes in the same cycle as an overflow tick, the service wins: no pulse, and `wd_cnt` becomes 0.
- R10: While `wd_rst` is high, control writes and service strobes are ignored.
- R11: Control bits [5:3] always read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prot_open | input | 1 | Strobe that opens the write window |
| prot_close | input | 1 | Strobe that closes the write window |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 8 | Control write data {flag, disable, check[2:0], prescale[2:0]} |
| svc_wr | input | 1 | Service key strobe |
| svc_key | input | 8 | Service key value |
| ctl_rdata | output | 8 | Control readback {flag, disable, 000, prescale} |
| wd_cnt | output | CNT_W | Current watchdog count |
| wd_rst | output | 1 | Reset pulse |

## Verification
The bench aims at these corner cases, and each item says what a design that got it wrong would do:
- A service sequence that completes on the very tick that would overflow. A design that ranked the overflow first would emit a spurious pulse.
- A bad-pattern write made while the disable bit is set. A design that gated faults with the disable bit would never reset there.
- Bad-pattern writes made with the window closed, and an open strobe coinciding with a close strobe. A weak protection gate would fire or change fields.
- Abort and repeat orders of the service keys, writes and keys during the pulse, and the one-cycle lag of the disable bit. A reference model compared every clock exposes any counter, flag or prescale step that is off by one.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        ST_COUNT = 2'd0,
        ST_HOLD  = 2'd1,
        ST_PULSE = 2'd2
    } wd_state_e;

    typedef enum logic {
        KEY_IDLE  = 1'b0,
        KEY_ARMED = 1'b1
    } key_state_e;

    localparam int CTL_W = 8;
    localparam logic [2:0] CHK_PATTERN = 3'b101;

    // Control word layout; the check field position is fixed by the write format.
    typedef struct packed {
        logic       flag;
        logic       dis;
        logic [2:0] chk;
        logic [2:0] ps;
    } ctl_word_t;

endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int FIX_DIV = 512   // power of two
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic       clear_i,
    input  logic [2:0] sel_i,
    output logic       tick_o
);
    localparam int PW = $clog2(FIX_DIV) + 7;

    logic [PW-1:0] phase_q;
    logic [PW-1:0] limit;
    logic [2:0]    shamt;

    always_comb begin
        shamt = (sel_i == 3'd0) ? 3'd0 : (sel_i - 3'd1);
        limit = (PW'(FIX_DIV) << shamt) - PW'(1);
    end

    assign tick_o = run_i && (phase_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (clear_i) begin
            phase_q <= '0;
        end else if (run_i) begin
            phase_q <= tick_o ? '0 : phase_q + PW'(1);
        end
    end

    // R6: a stopped timebase keeps its phase
    p_phase_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !clear_i) |=> $stable(phase_q));

    // R2: every tick restarts the phase
    p_tick_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (phase_q == '0));

endmodule

// File: rtl/wdog_keyseq.sv
module wdog_keyseq
    import wdog_pkg::*;
#(
    parameter logic [7:0] KEY_FIRST  = 8'h55,
    parameter logic [7:0] KEY_SECOND = 8'hAA
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       busy_i,
    input  logic       flush_i,
    input  logic       svc_wr_i,
    input  logic [7:0] svc_key_i,
    output logic       svc_ok_o
);
    key_state_e ks_q, ks_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ks_q <= KEY_IDLE;
        else        ks_q <= ks_d;
    end

    always_comb begin
        ks_d = ks_q;
        if (flush_i) begin
            ks_d = KEY_IDLE;
        end else if (svc_wr_i) begin
            unique case (ks_q)
                KEY_IDLE:  ks_d = (svc_key_i == KEY_FIRST) ? KEY_ARMED : KEY_IDLE;
                KEY_ARMED: ks_d = (svc_key_i == KEY_FIRST) ? KEY_ARMED : KEY_IDLE;
                default:   ks_d = KEY_IDLE;
            endcase
        end
    end

    always_comb begin
        svc_ok_o = !busy_i && svc_wr_i && (ks_q == KEY_ARMED)
                   && (svc_key_i == KEY_SECOND);
    end

    // R8: a second key without a prior first key is never accepted
    p_key_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_wr_i && !svc_ok_o && svc_key_i != KEY_FIRST) |=> (ks_q == KEY_IDLE));

endmodule

// File: rtl/wdog_ctlreg.sv
module wdog_ctlreg
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prot_open_i,
    input  logic             prot_close_i,
    input  logic             wr_i,
    input  logic [CTL_W-1:0] wdata_i,
    input  logic             busy_i,
    input  logic             fire_i,
    output logic [2:0]       ps_o,
    output logic             dis_o,
    output logic             bad_wr_o,
    output logic [CTL_W-1:0] rdata_o
);
    ctl_word_t  wd;
    logic       win_q;
    logic       flag_q;
    logic       dis_q;
    logic [2:0] ps_q;
    logic       wr_ok;
    logic       good_wr;

    always_comb begin
        wd       = ctl_word_t'(wdata_i);
        wr_ok    = wr_i && win_q && !busy_i;
        bad_wr_o = wr_ok && (wd.chk != CHK_PATTERN);
        good_wr  = wr_ok && (wd.chk == CHK_PATTERN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= 1'b0;
        end else if (fire_i || prot_close_i) begin
            win_q <= 1'b0;
        end else if (prot_open_i) begin
            win_q <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_q   <= 3'd0;
            dis_q  <= 1'b0;
            flag_q <= 1'b0;
        end else if (fire_i) begin
            ps_q   <= 3'd0;
            dis_q  <= 1'b0;
            flag_q <= 1'b1;
        end else if (good_wr) begin
            ps_q  <= wd.ps;
            dis_q <= wd.dis;
            if (wd.flag) flag_q <= 1'b0;
        end
    end

    assign ps_o    = ps_q;
    assign dis_o   = dis_q;
    assign rdata_o = {flag_q, dis_q, 3'b000, ps_q};

    // R4: every bad-pattern write must be turned into a fire event by the sequencer
    p_bad_fires_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bad_wr_o |-> fire_i);

    // R5: with the window closed nothing but a fire alters the fields
    p_closed_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_q && !fire_i) |=> $stable({flag_q, dis_q, ps_q}));

    // R3: a fire records the cause and restores defaults
    p_fire_defaults_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fire_i |=> (flag_q && !dis_q && ps_q == 3'd0 && !win_q));

    // R7: writing one to the flag clears it
    p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (good_wr && wd.flag && !fire_i) |=> !flag_q);

endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int PULSE_LEN = 512   // at least 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dis_i,
    input  logic             tick_i,
    input  logic             svc_ok_i,
    input  logic             bad_wr_i,
    output logic             fire_o,
    output logic             busy_o,
    output logic             run_o,
    output logic             wd_rst_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam int PCW = $clog2(PULSE_LEN);
    localparam logic [PCW-1:0] PC_LAST = PCW'(PULSE_LEN - 1);

    wd_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [PCW-1:0]   pcnt_q;
    logic             at_top;

    always_comb begin
        at_top = (cnt_q == {CNT_W{1'b1}});
        fire_o = bad_wr_i || (tick_i && at_top && !svc_ok_i);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_COUNT;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_COUNT: begin
                if (fire_o)     state_d = ST_PULSE;
                else if (dis_i) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (fire_o)      state_d = ST_PULSE;
                else if (!dis_i) state_d = ST_COUNT;
            end
            ST_PULSE: begin
                if (pcnt_q == PC_LAST) state_d = ST_COUNT;
            end
            default: state_d = ST_COUNT;
        endcase
    end

    // outputs
    always_comb begin
        run_o    = (state_q == ST_COUNT);
        busy_o   = (state_q == ST_PULSE);
        wd_rst_o = (state_q == ST_PULSE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (fire_o || svc_ok_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  pcnt_q <= '0;
        else if (state_q != ST_PULSE) pcnt_q <= '0;
        else                         pcnt_q <= pcnt_q + PCW'(1);
    end

    assign cnt_o = cnt_q;

    // R3: a fire enters the pulse with the counter cleared
    p_fire_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> (wd_rst_o && cnt_q == '0));

    // R3: the pulse ends after its last cycle
    p_pulse_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PULSE && pcnt_q == PC_LAST) |=> !wd_rst_o);

    // R6: a held counter does not move
    p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !svc_ok_i && !fire_o) |=> $stable(cnt_q));

    // R8: a completed key sequence clears the count
    p_svc_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        svc_ok_i |=> (cnt_q == '0 && !wd_rst_o));

    // R10: nothing starts a fresh pulse while one runs
    p_busy_no_fire_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !fire_o);

endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
    import wdog_pkg::*;
#(
    parameter int         FIX_DIV    = 512,
    parameter int         CNT_W      = 8,
    parameter int         PULSE_LEN  = 512,
    parameter logic [7:0] KEY_FIRST  = 8'h55,
    parameter logic [7:0] KEY_SECOND = 8'hAA
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prot_open,
    input  logic             prot_close,
    input  logic             ctl_wr,
    input  logic [7:0]       ctl_wdata,
    input  logic             svc_wr,
    input  logic [7:0]       svc_key,
    output logic [7:0]       ctl_rdata,
    output logic [CNT_W-1:0] wd_cnt,
    output logic             wd_rst
);
    logic       fire;
    logic       busy;
    logic       run;
    logic       tick;
    logic       svc_ok;
    logic       bad_wr;
    logic       dis;
    logic [2:0] ps;

    wdog_ctlreg u_ctlreg (
        .clk          (clk),
        .rst_n        (rst_n),
        .prot_open_i  (prot_open),
        .prot_close_i (prot_close),
        .wr_i         (ctl_wr),
        .wdata_i      (ctl_wdata),
        .busy_i       (busy),
        .fire_i       (fire),
        .ps_o         (ps),
        .dis_o        (dis),
        .bad_wr_o     (bad_wr),
        .rdata_o      (ctl_rdata)
    );

    wdog_keyseq #(
        .KEY_FIRST  (KEY_FIRST),
        .KEY_SECOND (KEY_SECOND)
    ) u_keyseq (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy_i    (busy),
        .flush_i   (fire || busy),
        .svc_wr_i  (svc_wr),
        .svc_key_i (svc_key),
        .svc_ok_o  (svc_ok)
    );

    wdog_prescaler #(
        .FIX_DIV (FIX_DIV)
    ) u_prescaler (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run),
        .clear_i (svc_ok || fire),
        .sel_i   (ps),
        .tick_o  (tick)
    );

    wdog_fsm #(
        .CNT_W     (CNT_W),
        .PULSE_LEN (PULSE_LEN)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .dis_i    (dis),
        .tick_i   (tick),
        .svc_ok_i (svc_ok),
        .bad_wr_i (bad_wr),
        .fire_o   (fire),
        .busy_o   (busy),
        .run_o    (run),
        .wd_rst_o (wd_rst),
        .cnt_o    (wd_cnt)
    );

endmodule

// File: tb/wdog_ctrl_tb.sv
module wdog_ctrl_tb;
    localparam int FD = 4;
    localparam int CW = 4;
    localparam int PL = 8;
    localparam logic [7:0] KA = 8'h55;
    localparam logic [7:0] KB = 8'hAA;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          prot_open = 1'b0, prot_close = 1'b0;
    logic          ctl_wr = 1'b0;
    logic [7:0]    ctl_wdata = 8'h00;
    logic          svc_wr = 1'b0;
    logic [7:0]    svc_key = 8'h00;
    logic [7:0]    ctl_rdata;
    logic [CW-1:0] wd_cnt;
    logic          wd_rst;

    always #5 clk = ~clk;

    wdog_ctrl #(.FIX_DIV(FD), .CNT_W(CW), .PULSE_LEN(PL),
                .KEY_FIRST(KA), .KEY_SECOND(KB)) u_dut (
        .clk(clk), .rst_n(rst_n), .prot_open(prot_open), .prot_close(prot_close),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .svc_wr(svc_wr), .svc_key(svc_key),
        .ctl_rdata(ctl_rdata), .wd_cnt(wd_cnt), .wd_rst(wd_rst));

    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc = 0;
    bit    cmp_on = 1'b0;
    string cur_req = "R1";

    // behavioural reference
    int m_mode, m_pre, m_cnt, m_pc, m_win, m_ps, m_dis, m_flag, m_arm;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_pre = 0; m_cnt = 0; m_pc = 0; m_win = 0;
            m_ps = 0; m_dis = 0; m_flag = 0; m_arm = 0;
        end else begin
            int  period;
            bit  busy, wok, bad, good, sok, tick, fire;
            busy   = (m_mode == 2);
            wok    = ctl_wr && (m_win == 1) && !busy;
            bad    = wok && (ctl_wdata[5:3] != 3'b101);
            good   = wok && !bad;
            sok    = !busy && (m_arm == 1) && svc_wr && (svc_key == KB);
            period = (m_ps == 0) ? FD : FD * (1 << (m_ps - 1));
            tick   = (m_mode == 0) && (m_pre == period - 1);
            fire   = bad || (tick && m_cnt == CMAX && !sok);
            if (fire || sok)        m_pre = 0;
            else if (m_mode == 0)   m_pre = tick ? 0 : m_pre + 1;
            if (fire || sok)        m_cnt = 0;
            else if (tick)          m_cnt = m_cnt + 1;
            if (fire)                m_arm = 0;
            else if (busy)           m_arm = 0;
            else if (svc_wr)         m_arm = (svc_key == KA) ? 1 : 0;
            if (fire) begin
                m_mode = 2; m_pc = 0;
            end else if (m_mode == 0) begin
                if (m_dis == 1) m_mode = 1;
            end else if (m_mode == 1) begin
                if (m_dis == 0) m_mode = 0;
            end else begin
                if (m_pc == PL - 1) m_mode = 0;
                else m_pc = m_pc + 1;
            end
            if (fire || prot_close) m_win = 0;
            else if (prot_open)     m_win = 1;
            if (fire) begin
                m_ps = 0; m_dis = 0; m_flag = 1;
            end else if (good) begin
                m_ps  = int'(ctl_wdata[2:0]);
                m_dis = int'(ctl_wdata[6]);
                if (ctl_wdata[7]) m_flag = 0;
            end
        end
    end

    function automatic int exp_rd();
        return (m_flag << 7) | (m_dis << 6) | m_ps;
    endfunction

    always @(negedge clk) begin
        if (cmp_on) begin
            n_chk++;
            if (wd_rst !== (m_mode == 2) || int'(wd_cnt) != m_cnt
                || int'(ctl_rdata) != exp_rd()) begin
                n_fail++;
                $display("FAIL %s: rst=%0d cnt=%0d rd=%02h expected rst=%0d cnt=%0d rd=%02h",
                         cur_req, wd_rst, wd_cnt, ctl_rdata, (m_mode == 2), m_cnt, exp_rd());
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            summary();
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk); ctl_wr = 1'b1; ctl_wdata = d;
        @(negedge clk); ctl_wr = 1'b0;
    endtask

    task automatic svc(input logic [7:0] k);
        @(negedge clk); svc_wr = 1'b1; svc_key = k;
        @(negedge clk); svc_wr = 1'b0;
    endtask

    task automatic win_open();
        @(negedge clk); prot_open = 1'b1;
        @(negedge clk); prot_open = 1'b0;
    endtask

    task automatic win_close();
        @(negedge clk); prot_close = 1'b1;
        @(negedge clk); prot_close = 1'b0;
    endtask

    initial begin
        int plen;
        int held;
        idle(3);
        rst_n = 1'b1;
        check("R1 rdata", int'(ctl_rdata), 0);
        check("R1 cnt", int'(wd_cnt), 0);
        check("R1 wd_rst", int'(wd_rst), 0);
        @(negedge clk);
        cmp_on = 1'b1;

        // R2/R3: free-running count to overflow, measure pulse
        cur_req = "R2";
        while (!wd_rst) @(negedge clk);
        cur_req = "R3";
        plen = 0;
        while (wd_rst) begin plen++; @(negedge clk); end
        check("R3 pulse length", plen, PL);
        check("R3 flag set, defaults", int'(ctl_rdata), 8'h80);

        // R7: flag clear semantics, R11 check bits read zero
        cur_req = "R7";
        win_open();
        wr(8'h28);
        check("R7 flag kept on zero", int'(ctl_rdata), 8'h80);
        wr(8'hA8);
        check("R7 flag cleared on one", int'(ctl_rdata), 8'h00);

        // R2: slower prescale
        cur_req = "R2";
        wr(8'h2B);
        check("R11 readback ps=3", int'(ctl_rdata), 8'h03);
        idle(40);

        // R6: disable via 0x68 and resume
        cur_req = "R6";
        wr(8'h68);
        check("R6 disable readback", int'(ctl_rdata), 8'h40);
        idle(2);
        held = int'(wd_cnt);
        idle(30);
        check("R6 counter held", int'(wd_cnt), held);
        wr(8'h28);
        idle(10);

        // R8: service key orderings
        cur_req = "R8";
        svc(KA); svc(KB);
        check("R8 service clears", int'(wd_cnt), 0);
        idle(12);
        svc(KA); svc(8'h12); svc(KB);
        check("R8 aborted sequence no clear", int'(wd_cnt != 0), 1);
        svc(KB);
        check("R8 lone second key no clear", int'(wd_cnt != 0), 1);
        svc(KA); svc(KA); svc(KB);
        check("R8 repeated first key", int'(wd_cnt), 0);

        // R5: protection window
        cur_req = "R5";
        win_close();
        wr(8'h10);
        check("R5 closed bad write no pulse", int'(wd_rst), 0);
        wr(8'h6B);
        check("R5 closed write ignored", int'(ctl_rdata), 8'h00);
        @(negedge clk); prot_open = 1'b1; prot_close = 1'b1;
        @(negedge clk); prot_open = 1'b0; prot_close = 1'b0;
        wr(8'h2C);
        check("R5 open+close leaves closed", int'(ctl_rdata), 8'h00);
        svc(KA); svc(KB);

        // R4: bad pattern while disabled
        cur_req = "R4";
        win_open();
        wr(8'h68);
        wr(8'h70);
        check("R4 bad pattern fires", int'(wd_rst), 1);
        check("R4 fields after fault", int'(ctl_rdata), 8'h80);

        // R10: writes and service ignored during pulse
        cur_req = "R10";
        win_open();
        wr(8'h2C);
        check("R10 write ignored in pulse", int'(ctl_rdata), 8'h80);
        svc(KA); svc(KB);
        while (wd_rst) @(negedge clk);
        check("R10 after pulse fields", int'(ctl_rdata), 8'h80);

        // R9: service on the overflow tick
        cur_req = "R9";
        while (int'(wd_cnt) != CMAX) @(negedge clk);
        @(negedge clk);
        @(negedge clk); svc_wr = 1'b1; svc_key = KA;
        @(negedge clk); svc_key = KB;
        @(negedge clk); svc_wr = 1'b0;
        check("R9 no pulse", int'(wd_rst), 0);
        check("R9 counter cleared", int'(wd_cnt), 0);
        idle(4);
        check("R9 still no pulse", int'(wd_rst), 0);

        cmp_on = 1'b0;
        summary();
        $finish;
    end

endmodule